// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell

This block is a two-port RAM in which the top two words also act as doorbells between the ports. Each port owns one mailbox word. The left port owns the highest address and the right port owns the word just below it. When a port writes the other port's mailbox, the owner's active-low interrupt line is asserted. The owner drops that interrupt by reading its own mailbox with the output enable high. Usually that read also fetches the message the other port left there.

Both mailbox words remain ordinary storage. Either port can read or write them like any other word. An interrupt changes only as a side effect of these normal accesses. The mailbox addresses are computed from the depth parameter, so the same code works for any power-of-two depth.

Top module: `mbox_irq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `l_irq_n` and `r_irq_n` are 1 and both read-data outputs are 0.
- R2: If the right port writes (en=1, wr=1) address DEPTH-1, `l_irq_n` is 0 after the next clock edge. With the default DEPTH of 1024, that address is 0x3FF.
- R3: If the left port writes address DEPTH-2 (0x3FE by default), `r_irq_n` is 0 after the next clock edge.
- R4: A read (en=1, wr=0, oe=1) by the left port of DEPTH-1 sets `l_irq_n` back to 1 at the next edge. The same kind of read by the right port of DEPTH-2 sets `r_irq_n` back to 1.
- R5: A read with oe=0 leaves the interrupt unchanged, even when the address is the port's own mailbox.
- R6: A port that writes its own mailbox, or any access to a non-mailbox address, leaves both interrupts unchanged.
- R7: If the set and the clear of one interrupt happen in the same cycle, the interrupt ends up asserted (0).
- R8: A read returns the word at that address one cycle later, as it was before any write in the same cycle. This holds for the mailbox words too, which store ordinary data.
- R9: If both ports write the same address in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port output enable; a read counts only when this is high |
| l_addr | input | AW (10) | Left port word address |
| l_wdata | input | DW (8) | Left port write data |
| l_rdata | output | DW (8) | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | AW (10) | Right port word address |
| r_wdata | input | DW (8) | Right port write data |
| r_rdata | output | DW (8) | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Each interrupt is a single register, so a wrong flag state appears on the matching `*_irq_n` pin one edge after the access that caused it. No later event can hide it, because the flag holds until a legal clear or set arrives. A faulty address decode shows up the same way: an interrupt moves after a write to the port's own mailbox or to a nearby word, or fails to move after the doorbell write. Storage faults appear on the read-data outputs one cycle after a read. That includes the mailbox words and a same-cycle write collision.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;

  // Mailbox owned by a port: left owns the top word, right the one below.
  function automatic int unsigned own_box(input port_e side, input int unsigned depth);
    return (side == PORT_L) ? depth - 1 : depth - 2;
  endfunction

  function automatic int unsigned peer_box(input port_e side, input int unsigned depth);
    return (side == PORT_L) ? depth - 2 : depth - 1;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter port_e       SIDE  = PORT_L,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          en,
  input  logic          wr,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  output logic          ring_peer,
  output logic          ack_own
);
  localparam logic [AW-1:0] OWN_A  = AW'(own_box(SIDE, DEPTH));
  localparam logic [AW-1:0] PEER_A = AW'(peer_box(SIDE, DEPTH));

  always_comb begin
    ring_peer = en &  wr &       (addr == PEER_A);
    ack_own   = en & ~wr & oe &  (addr == OWN_A);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)      irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;   // set has priority over clear
    else if (clr) irq_n <= 1'b1;
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Port b written first so port a wins a same-address collision.
  always_ff @(posedge clk) begin
    if (b_en && b_wr) mem[b_addr] <= b_wdata;
    if (a_en && a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en && !a_wr) a_rdata <= mem[a_addr];
      if (b_en && !b_wr) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  logic [1:0]    en_v, wr_v, oe_v, ring, ack, irq_v;
  logic [AW-1:0] addr_v [2];

  assign en_v = {r_en, l_en};
  assign wr_v = {r_wr, l_wr};
  assign oe_v = {r_oe, l_oe};
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  for (genvar i = 0; i < 2; i++) begin : g_port
    mbox_decode #(.DEPTH(DEPTH), .SIDE(port_e'(i))) u_dec (
      .en(en_v[i]), .wr(wr_v[i]), .oe(oe_v[i]), .addr(addr_v[i]),
      .ring_peer(ring[i]), .ack_own(ack[i])
    );
    // Flag i is rung by the opposite port and acknowledged by its owner.
    mbox_flag u_flag (
      .clk(clk), .rst(rst), .set(ring[1-i]), .clr(ack[i]), .irq_n(irq_v[i])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

  mbox_dpram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .rst(rst),
    .a_en(l_en), .a_wr(l_wr), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
    .b_en(r_en), .b_wr(r_wr), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
  );
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          l_en,
  input logic          l_wr,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic          l_irq_n,
  input logic          r_en,
  input logic          r_wr,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  localparam logic [AW-1:0] NXT = AW'(DEPTH - 2);

  logic set_l, set_r, clr_l, clr_r;
  assign set_l = r_en && r_wr && r_addr == TOP;
  assign set_r = l_en && l_wr && l_addr == NXT;
  assign clr_l = l_en && !l_wr && l_oe && l_addr == TOP;
  assign clr_r = r_en && !r_wr && r_oe && r_addr == NXT;

  p_reset_r1: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n));
  p_set_left_r2: assert property (@(posedge clk) disable iff (rst) set_l |=> !l_irq_n);
  p_set_right_r3: assert property (@(posedge clk) disable iff (rst) set_r |=> !r_irq_n);
  p_clear_left_r4: assert property (@(posedge clk) disable iff (rst) (clr_l && !set_l) |=> l_irq_n);
  p_clear_right_r4: assert property (@(posedge clk) disable iff (rst) (clr_r && !set_r) |=> r_irq_n);
  p_hold_left_r6: assert property (@(posedge clk) disable iff (rst) (!set_l && !clr_l) |=> $stable(l_irq_n));
  p_hold_right_r6: assert property (@(posedge clk) disable iff (rst) (!set_r && !clr_r) |=> $stable(r_irq_n));
endmodule

bind mbox_irq mbox_irq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_irq_n(l_irq_n),
  .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_irq_n(r_irq_n)
);

// File: tb/test_mbox_irq.sv
module test_mbox_irq;
  localparam int unsigned DEPTH = 1024;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  localparam logic [AW-1:0] NXT = AW'(DEPTH - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  mbox_irq #(.DEPTH(DEPTH), .DW(DW)) i_mbox_irq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access per port in one cycle; returns at the negedge after the edge.
  task automatic acc(input logic le, input logic lw, input logic lo, input logic [AW-1:0] la,
                     input logic [DW-1:0] ld, input logic re, input logic rw, input logic ro,
                     input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    l_en = le; l_wr = lw; l_oe = lo; l_addr = la; l_wdata = ld;
    r_en = re; r_wr = rw; r_oe = ro; r_addr = ra; r_wdata = rd;
    @(negedge clk);
    l_en = 0; l_wr = 0; l_oe = 0; r_en = 0; r_wr = 0; r_oe = 0;
  endtask

  task automatic t_reset;
    chk("R1 l_irq_n", l_irq_n, 1);
    chk("R1 r_irq_n", r_irq_n, 1);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
  endtask

  task automatic t_left_doorbell;
    acc(0,0,0,'0,'0, 1,1,0,TOP,8'hA5);
    chk("R2 l_irq_n set", l_irq_n, 0);
    chk("R2 r_irq_n untouched", r_irq_n, 1);
    acc(1,0,0,TOP,'0, 0,0,0,'0,'0);
    chk("R5 no clear without oe", l_irq_n, 0);
    chk("R8 mailbox data", l_rdata, 8'hA5);
    acc(1,0,1,TOP,'0, 0,0,0,'0,'0);
    chk("R4 left clear", l_irq_n, 1);
  endtask

  task automatic t_right_doorbell;
    acc(1,1,0,NXT,8'h3C, 0,0,0,'0,'0);
    chk("R3 r_irq_n set", r_irq_n, 0);
    chk("R3 l_irq_n untouched", l_irq_n, 1);
    acc(0,0,0,'0,'0, 1,1,0,NXT,8'h77);
    chk("R6 own write keeps irq", r_irq_n, 0);
    acc(0,0,0,'0,'0, 1,0,1,NXT,'0);
    chk("R4 right clear", r_irq_n, 1);
    chk("R8 right reads own box", r_rdata, 8'h77);
  endtask

  task automatic t_no_side_effect;
    acc(1,1,0,TOP,8'h12, 1,1,0,NXT-1,8'h34);
    chk("R6 left own write", l_irq_n, 1);
    chk("R6 other address", r_irq_n, 1);
    acc(1,0,1,NXT-1,'0, 1,0,1,TOP,'0);
    chk("R8 plain word", l_rdata, 8'h34);
    chk("R8 right reads left box", r_rdata, 8'h12);
    chk("R6 peer read no effect", l_irq_n, 1);
  endtask

  task automatic t_race;
    acc(1,0,1,TOP,'0, 1,1,0,TOP,8'h5A);
    chk("R7 set wins", l_irq_n, 0);
    chk("R8 read-before-write", l_rdata, 8'h12);
    acc(1,0,1,TOP,'0, 0,0,0,'0,'0);
    chk("R4 clear after race", l_irq_n, 1);
    chk("R8 new box data", l_rdata, 8'h5A);
  endtask

  task automatic t_collision;
    acc(1,1,0,AW'(5),8'h11, 1,1,0,AW'(5),8'h22);
    acc(1,0,1,AW'(5),'0, 0,0,0,'0,'0);
    chk("R9 left wins", l_rdata, 8'h11);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_left_doorbell();
        t_right_doorbell();
        t_no_side_effect();
        t_race();
        t_collision();
      end
      begin
        repeat (5000) @(negedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule